// File: doc/BRIEF.md
# Sticky Interrupt Source Controller

This block gathers six interrupt causes into a sticky source register and drives a single level interrupt toward the processor. Some causes are single-cycle events, such as the end of a waveform capture or a timing-receiver interrupt. The block latches these on their rising edge. The other causes are persistent conditions, such as the OR of the power-module channel faults, the OR of the magnet faults, a message-available flag or a general-purpose input. Their bits are forced set for as long as the condition is present.

Software reads and acknowledges the sources through a small word-addressed register port. An acknowledge writes a '1' to a source bit, but the bit is only cleared if its cause has gone away. While a level cause is still present, or when a fresh event edge lands in the same cycle as the acknowledge, the bit stays set and the interrupt stays raised. A mask register gates which sources reach the output. Software changes the mask only through separate set and clear addresses, so each write touches only the bits written as '1'.

The interrupt output is one register stage after the source and mask registers. A parameter chooses which bit positions are treated as events and which as levels.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset the source register reads 0, the enable register reads 0 and `irqOut` is 0.
- R2: For an event source (bits 0 and 3 by default), a rising edge on its cause sets the source bit at that clock edge. The bit stays set after the cause drops.
- R3: For a level source (bits 1, 2, 4 and 5 by default), the source bit is set at every clock edge at which the cause is high.
- R4: A write to word address 0 clears each source bit written as '1' whose cause is inactive. Bits written as '0' are unchanged, and a set bit stays set until it is acknowledged.
- R5: An acknowledge of a level source whose cause is still high leaves the bit set, and the interrupt remains asserted.
- R6: An acknowledge of an event source in the same cycle as a new rising edge of its cause leaves the bit set.
- R7: A write to word address 2 sets the enable bits written as '1'. A write to word address 3 clears the enable bits written as '1'. Other enable bits are unchanged.
- R8: `irqOut` equals the OR over all bits of (source AND enable) as held in the registers one clock edge earlier.
- R9: Reads return the source at address 0 and the enable at address 1, with bits 31:6 as zero. Every other address reads zero. Writes to address 1 or to any address above 3 change nothing.
- R10: An event cause that is held high sets its bit only once. An acknowledge made while the cause is still held high, with no new edge, clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| causeIn | input | 6 | Raw interrupt causes, synchronous to clk |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 4 | Register word address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational on busAddr |
| irqOut | output | 1 | Registered level interrupt |

## Verification
The bench acknowledges a level source while its cause is still high. A design that clears unconditionally would drop the bit and release the interrupt there. It also lands an event edge in the same cycle as the acknowledge of that bit, which catches a design that lets the clear win. It holds an event cause high across an acknowledge: a level-style design would refuse the clear, and an edge detector that fails to remember the old value would set the bit again. The bench also watches the single cycle of latency on the interrupt after an enable write, and checks that writes to the read-only enable address are ignored.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  // Number of interrupt sources collected by the block.
  localparam int NUM_SRC = 6;

  // Register word addresses.
  localparam int ADDR_SOURCE  = 0;
  localparam int ADDR_ENABLE  = 1;
  localparam int ADDR_EN_SET  = 2;
  localparam int ADDR_EN_CLR  = 3;

  // Strobes from the register decoder to the datapath, one bit per source.
  typedef struct packed {
    logic [NUM_SRC-1:0] ack;
    logic [NUM_SRC-1:0] enSet;
    logic [NUM_SRC-1:0] enClr;
  } irq_strobe_t;

endpackage

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [NUM_SRC-1:0] srcQ,
  input  logic [NUM_SRC-1:0] enQ,
  output irq_strobe_t       strb,
  output logic [DATA_W-1:0] busRdata
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] wBits;
  logic               unusedHiBits;

  assign wBits        = busWdata[NUM_SRC-1:0];
  assign unusedHiBits = ^busWdata[DATA_W-1:NUM_SRC];

  // Write decode: one strobe group per writable address.
  always_comb begin
    strb = '0;
    if (busWr) begin
      unique case (int'(busAddr))
        ADDR_SOURCE: strb.ack   = wBits;
        ADDR_EN_SET: strb.enSet = wBits;
        ADDR_EN_CLR: strb.enClr = wBits;
        default:     strb       = '0;
      endcase
    end
  end

  // Read mux: unused upper bits and unmapped addresses read zero.
  always_comb begin
    unique case (int'(busAddr))
      ADDR_SOURCE: busRdata = {{PAD_W{1'b0}}, srcQ};
      ADDR_ENABLE: busRdata = {{PAD_W{1'b0}}, enQ};
      default:     busRdata = '0;
    endcase
  end

  // At most one strobe group is active in a cycle (R7, R4).
  p_one_strobe_group_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({|strb.ack, |strb.enSet, |strb.enClr}));

  // No write strobe without a bus write (R9).
  p_no_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |-> (strb == '0));

endmodule

// File: rtl/irq_src_datapath.sv
module irq_src_datapath
  import irq_src_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] PULSE_MASK = 6'b001001
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] causeIn,
  input  irq_strobe_t        strb,
  output logic [NUM_SRC-1:0] srcQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] setEvt;
  logic [NUM_SRC-1:0] srcNext;
  logic [NUM_SRC-1:0] enNext;

  // Per-source set logic: edge detect for event causes, pass-through for levels.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (PULSE_MASK[i]) begin : g_pulse
      logic prevQ;
      always_ff @(posedge clk) begin
        if (!rstN) prevQ <= 1'b0;
        else       prevQ <= causeIn[i];
      end
      assign setEvt[i] = causeIn[i] & ~prevQ;

      // A new edge always leaves the bit set, even against an ack (R2, R6).
      p_edge_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
        (causeIn[i] && !prevQ) |=> srcQ[i]);
    end else begin : g_level
      assign setEvt[i] = causeIn[i];

      // An active level keeps its bit set despite an ack (R3, R5).
      p_level_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
        causeIn[i] |=> srcQ[i]);
    end

    // Without an ack a set bit never drops (R4).
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
      (srcQ[i] && !strb.ack[i]) |=> srcQ[i]);
  end

  // Set beats clear, so a still-active cause keeps its bit.
  assign srcNext = (srcQ & ~strb.ack) | setEvt;
  assign enNext  = (enQ | strb.enSet) & ~strb.enClr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ   <= '0;
      enQ    <= '0;
      irqOut <= 1'b0;
    end else begin
      srcQ   <= srcNext;
      enQ    <= enNext;
      irqOut <= |(srcQ & enQ);
    end
  end

  // Interrupt output tracks the masked sources one edge later (R8).
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|(srcQ & enQ)) |=> irqOut);
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(|(srcQ & enQ)) |=> !irqOut);

  // Enable set and clear strobes take effect at the next edge (R7).
  p_en_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.enSet) |=> ((enQ & $past(strb.enSet)) == $past(strb.enSet)));
  p_en_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.enClr) |=> ((enQ & $past(strb.enClr)) == '0));

endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import irq_src_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter logic [NUM_SRC-1:0] PULSE_MASK = 6'b001001
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] causeIn,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);

  irq_strobe_t        strb;
  logic [NUM_SRC-1:0] srcQ;
  logic [NUM_SRC-1:0] enQ;

  irq_src_ctrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .srcQ     (srcQ),
    .enQ      (enQ),
    .strb     (strb),
    .busRdata (busRdata)
  );

  irq_src_datapath #(
    .PULSE_MASK (PULSE_MASK)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .causeIn (causeIn),
    .strb    (strb),
    .srcQ    (srcQ),
    .enQ     (enQ),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/test_irq_source_ctrl.sv
module test_irq_source_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  causeIn = '0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  irq_source_ctrl i_irq_source_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .causeIn  (causeIn),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks are entered and left just after a falling edge.
  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic cleanUp();
    causeIn = '0;
    @(negedge clk);
    busWrite(4'd0, 32'h3F);
    busWrite(4'd3, 32'h3F);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    busRead(4'd0, d); check("R1 source after reset", d, 32'h0);
    busRead(4'd1, d); check("R1 enable after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_pulse();
    logic [31:0] d;
    causeIn[0] = 1'b1;
    @(negedge clk);
    causeIn[0] = 1'b0;
    @(negedge clk);
    busRead(4'd0, d); check("R2 event bit0 latched after pulse", d, 32'h1);
    busWrite(4'd0, 32'h0);
    busRead(4'd0, d); check("R4 write of zero keeps bit", d, 32'h1);
    busWrite(4'd0, 32'h1);
    busRead(4'd0, d); check("R4 ack clears idle event bit", d, 32'h0);
    // Held event cause: set once, ack while held clears it.
    causeIn[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busRead(4'd0, d); check("R2 event bit3 set by edge", d, 32'h8);
    busWrite(4'd0, 32'h8);
    busRead(4'd0, d); check("R10 ack with held event clears", d, 32'h0);
    @(negedge clk);
    busRead(4'd0, d); check("R10 held event does not re-set", d, 32'h0);
    cleanUp();
  endtask

  task automatic t_level();
    logic [31:0] d;
    causeIn[1] = 1'b1;
    @(negedge clk);
    busRead(4'd0, d); check("R3 level bit1 set", d, 32'h2);
    busWrite(4'd0, 32'h2);
    busRead(4'd0, d); check("R5 ack refused while level high", d, 32'h2);
    causeIn[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    busRead(4'd0, d); check("R4 level bit sticky after cause drops", d, 32'h2);
    busWrite(4'd0, 32'h2);
    busRead(4'd0, d); check("R4 ack clears after cause gone", d, 32'h0);
    causeIn[5:4] = 2'b11;
    @(negedge clk);
    busRead(4'd0, d); check("R3 level bits 4 and 5 set", d, 32'h30);
    cleanUp();
  endtask

  task automatic t_coincide();
    logic [31:0] d;
    causeIn[0] = 1'b1;
    @(negedge clk);
    causeIn[0] = 1'b0;
    @(negedge clk);
    causeIn[0] = 1'b1;   // new edge in the same cycle as the ack
    busWrite(4'd0, 32'h1);
    busRead(4'd0, d); check("R6 ack with coincident edge keeps bit", d, 32'h1);
    cleanUp();
  endtask

  task automatic t_enable();
    logic [31:0] d;
    busWrite(4'd2, 32'h05);
    busRead(4'd1, d); check("R7 enable set 0x05", d, 32'h05);
    busWrite(4'd2, 32'h02);
    busRead(4'd1, d); check("R7 enable set keeps others", d, 32'h07);
    busWrite(4'd3, 32'h01);
    busRead(4'd1, d); check("R7 enable clear one bit", d, 32'h06);
    busWrite(4'd1, 32'h3F);
    busRead(4'd1, d); check("R9 write to enable address ignored", d, 32'h06);
    busWrite(4'd9, 32'h3F);
    busRead(4'd1, d); check("R9 write to unmapped address ignored", d, 32'h06);
    busWrite(4'd2, 32'hFFFF_FFC0);
    busRead(4'd1, d); check("R9 upper bits read zero", d, 32'h06);
    busRead(4'd5, d); check("R9 unmapped address reads zero", d, 32'h0);
    cleanUp();
  endtask

  task automatic t_irq();
    logic [31:0] d;
    causeIn[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 masked source gives no irq", {31'b0, irqOut}, 32'h0);
    busWrite(4'd2, 32'h04);
    check("R8 irq one edge after enable", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R8 irq asserted", {31'b0, irqOut}, 32'h1);
    busWrite(4'd0, 32'h04);
    @(negedge clk);
    check("R5 irq stays while level active", {31'b0, irqOut}, 32'h1);
    causeIn[2] = 1'b0;
    @(negedge clk);
    busWrite(4'd0, 32'h04);
    busRead(4'd0, d); check("R4 source cleared", d, 32'h0);
    check("R8 irq still high one edge after clear", {31'b0, irqOut}, 32'h1);
    @(negedge clk);
    check("R8 irq released", {31'b0, irqOut}, 32'h0);
    cleanUp();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_pulse();
    t_level();
    t_coincide();
    t_enable();
    t_irq();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule